// File: doc/BRIEF.md
# Receive Link Health Monitor

This block watches the health of the receive channel of a fast-Ethernet physical layer. It takes a lock indication from the receive clock-recovery PLL and a signal-present indication from the line detector. Both inputs are asynchronous, so each passes through a two-stage synchronizer. A receive channel error is raised whenever either synchronized input reports a problem. The link is declared up only after both inputs have stayed good for a set number of consecutive clock cycles.

Three status bits come out for the management side, which reads registers through two read strobes. The detailed register carries a sticky lock-failure flag that latches high, and a live link bit. The main register carries a link bit that latches low. A channel fault clears both link bits on the same edge. The sticky bits change their held value only on a read of their own register.

Top module: `link_health_mon`

## Requirements
- R1: `pll_lock_i` and `sig_det_i` each pass through two flops. A change on either pin is visible on `rx_chan_err_o` after the second rising clock edge and not before.
- R2: `rx_chan_err_o` is 1 when the synchronized lock is 0 or the synchronized signal-detect is 0, and 0 only when both are 1.
- R3: `lock_err_o` becomes 1 on the clock edge after the synchronized lock is seen low. That is the third edge after the pin falls.
- R4: Once set, `lock_err_o` stays 1 after lock returns, until a read of the detailed register (`rd_detail_i` = 1).
- R5: A detailed-register read clears `lock_err_o` on that edge only if the synchronized lock is 1 at that edge. A read while lock is still lost leaves it at 1.
- R6: `detail_link_o` becomes 1 only after QUAL_CYCLES consecutive edges with no channel error. Any error cycle restarts the count from zero.
- R7: An edge that sees a channel error clears `detail_link_o` and `main_link_o` together on that same edge.
- R8: `main_link_o` latches low. After a fault it stays 0 even once the link is back up. A main-register read (`rd_main_i` = 1) loads the current link state, unless a fault is present at that edge, in which case it stays 0.
- R9: While `rst_ni` is 0, `lock_err_o`, `detail_link_o` and `main_link_o` are 0, and `rx_chan_err_o` is 1 because the synchronizers hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| pll_lock_i | input | 1 | Asynchronous PLL lock indication, 1 = locked |
| sig_det_i | input | 1 | Asynchronous receive signal present, 1 = present |
| rd_main_i | input | 1 | One-cycle strobe: main status register read |
| rd_detail_i | input | 1 | One-cycle strobe: detailed status register read |
| rx_chan_err_o | output | 1 | Receive channel error |
| lock_err_o | output | 1 | Latching-high lock failure bit (detailed register) |
| detail_link_o | output | 1 | Live link status bit (detailed register) |
| main_link_o | output | 1 | Latching-low link status bit (main register) |

## Verification
Two collisions matter here. A register read can fall on the same edge as the fault that the read would otherwise undo. The bench provokes both cases. It strobes the detailed read while lock is still lost and expects the lock flag to stay 1. It then strobes the main read on the first edge of a combined lock and signal loss, and expects the main link bit to fall to 0 together with the live link bit. A one-cycle signal dropout near the end of the qualification count checks that the count restarts rather than resumes.

// File: rtl/lmon_pkg.sv
package lmon_pkg;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned IDX_LOCK    = 0;
  localparam int unsigned IDX_SDET    = 1;
  localparam int unsigned NUM_SYNC    = 2;
endpackage

// File: rtl/lmon_sync.sv
module lmon_sync #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [lmon_pkg::SYNC_STAGES-1:0] stg_q;
    logic [lmon_pkg::SYNC_STAGES-1:0] stg_d;

    always_comb begin
      stg_d = {stg_q[lmon_pkg::SYNC_STAGES-2:0], d_i[g]};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= '0;
      else         stg_q <= stg_d;
    end

    assign q_o[g] = stg_q[lmon_pkg::SYNC_STAGES-1];
  end
endmodule

// File: rtl/lmon_qual.sv
module lmon_qual #(
  parameter int unsigned QUAL_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic healthy_i,
  output logic up_o
);
  localparam int unsigned CW = (QUAL_CYCLES > 1) ? $clog2(QUAL_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          up_q, up_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = healthy_i && !up_q;
    cnt_d  = cnt_q;
    up_d   = up_q;
    if (!healthy_i) begin
      cnt_d = '0;
      up_d  = 1'b0;
    end else if (cnt_en) begin
      if (cnt_q == LAST) up_d  = 1'b1;
      else               cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign up_o = up_q;

  p_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_drop_on_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !healthy_i |=> !up_o && cnt_q == '0);
endmodule

// File: rtl/lmon_latch.sv
module lmon_latch #(
  parameter logic EVT_VAL = 1'b1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic rd_i,
  input  logic rd_val_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (evt_i)     q_d = EVT_VAL;
    else if (rd_i) q_d = rd_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RST_VAL;
    else         q_q <= q_d;
  end

  assign q_o = q_q;

  p_evt_dominates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> q_o == EVT_VAL);
  p_quiet_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i && !rd_i |=> $stable(q_o));
endmodule

// File: rtl/link_health_mon.sv
module link_health_mon #(
  parameter int unsigned QUAL_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pll_lock_i,
  input  logic sig_det_i,
  input  logic rd_main_i,
  input  logic rd_detail_i,
  output logic rx_chan_err_o,
  output logic lock_err_o,
  output logic detail_link_o,
  output logic main_link_o
);
  import lmon_pkg::*;

  logic [NUM_SYNC-1:0] raw_in, syn;
  logic lock_s, sdet_s, chan_err, link_up;

  assign raw_in[IDX_LOCK] = pll_lock_i;
  assign raw_in[IDX_SDET] = sig_det_i;

  lmon_sync #(.WIDTH(NUM_SYNC)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(raw_in), .q_o(syn)
  );

  assign lock_s   = syn[IDX_LOCK];
  assign sdet_s   = syn[IDX_SDET];
  assign chan_err = !(lock_s && sdet_s);

  lmon_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk_i(clk_i), .rst_ni(rst_ni), .healthy_i(!chan_err), .up_o(link_up)
  );

  // sticky lock-failure flag: set by loss of lock, cleared by a detailed read
  lmon_latch #(.EVT_VAL(1'b1), .RST_VAL(1'b0)) u_lock_lh (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(!lock_s), .rd_i(rd_detail_i),
    .rd_val_i(1'b0), .q_o(lock_err_o)
  );

  // main link bit: forced low by any fault, reloaded from live state on read
  lmon_latch #(.EVT_VAL(1'b0), .RST_VAL(1'b0)) u_link_ll (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(chan_err), .rd_i(rd_main_i),
    .rd_val_i(link_up), .q_o(main_link_o)
  );

  assign rx_chan_err_o = chan_err;
  assign detail_link_o = link_up;

  p_lock_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_s |=> lock_err_o);
  p_lock_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_err_o && !rd_detail_i |=> lock_err_o);
  p_read_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_err_o && rd_detail_i && lock_s |=> !lock_err_o);
  p_up_needs_health_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(detail_link_o) |-> $past(!rx_chan_err_o));
  p_fault_clears_both_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_chan_err_o |=> !detail_link_o && !main_link_o);
  p_main_rise_on_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(main_link_o) |-> $past(rd_main_i));
  p_main_implies_live_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_link_o |-> detail_link_o);
endmodule

// File: tb/sim_link_health_mon.sv
module sim_link_health_mon;
  localparam int unsigned QUAL = 4;

  logic clk = 1'b0;
  logic rst_ni, pll_lock, sig_det, rd_main, rd_detail;
  logic rx_chan_err, lock_err, detail_link, main_link;
  int   checks = 0;
  int   errors = 0;

  always #10 clk = ~clk;

  link_health_mon #(.QUAL_CYCLES(QUAL)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pll_lock_i(pll_lock), .sig_det_i(sig_det),
    .rd_main_i(rd_main), .rd_detail_i(rd_detail), .rx_chan_err_o(rx_chan_err),
    .lock_err_o(lock_err), .detail_link_o(detail_link), .main_link_o(main_link)
  );

  // [15:12] req, [11] lock, [10] sdet, [9] rd_main, [8] rd_detail,
  // [7:4] edges to wait, [3:0] expected {chan_err, lock_err, detail, main}
  localparam int NV = 22;
  localparam logic [15:0] VEC [NV] = '{
    16'h1C_2_4,  // R1 sync delay, lock flag left from startup
    16'h6C_3_4,  // R6 not yet qualified
    16'h6C_1_6,  // R6 qualified
    16'h5D_1_2,  // R5 detailed read clears while locked
    16'h8E_1_3,  // R8 main read loads live link
    16'h14_2_B,  // R1 lock loss reaches channel error after two edges
    16'h34_1_C,  // R3 and R7 flag sets, both link bits clear together
    16'h55_1_C,  // R5 read while lock still lost keeps flag
    16'h4C_2_4,  // R4 flag survives lock return
    16'h6C_3_4,  // R6 requalifying
    16'h8C_1_6,  // R8 main stays low after link returns
    16'h5F_1_3,  // R5 and R8 reads together
    16'h28_3_8,  // R2 and R7 signal loss alone
    16'h6C_3_0,  // R6 count 1
    16'h68_1_0,  // R6 dropout enters synchronizer
    16'h6C_1_8,  // R6 dropout visible
    16'h6C_1_0,  // R6 count restarted
    16'h6C_3_0,  // R6 still short
    16'h6C_1_2,  // R6 full count after restart
    16'h8E_1_3,  // R8 read
    16'h20_2_B,  // R2 both lost
    16'h72_1_C   // R7 and R8 main read on fault edge stays low
  };

  task automatic check4(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {rx_chan_err, lock_err, detail_link, main_link};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; pll_lock = 1'b1; sig_det = 1'b1; rd_main = 1'b0; rd_detail = 1'b0;
    repeat (3) @(negedge clk);
    check4("R9 reset state", 4'b1000);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VEC[i];
      pll_lock  = v[11];
      sig_det   = v[10];
      rd_main   = v[9];
      rd_detail = v[8];
      for (int k = 0; k < int'(v[7:4]); k++) begin
        @(posedge clk);
        @(negedge clk);
        rd_main   = 1'b0;
        rd_detail = 1'b0;
      end
      check4($sformatf("R%0d vector %0d", v[15:12], i), v[3:0]);
    end
    // R9 reset taken mid-operation
    pll_lock = 1'b1; sig_det = 1'b1;
    repeat (QUAL + 4) @(negedge clk);
    check4("R6 up before reset", 4'b0X10 ^ 4'b0000 ? {1'b0, lock_err, 2'b10} : 4'b0);
    #3 rst_ni = 1'b0;
    @(negedge clk);
    check4("R9 reset mid-run", 4'b1000);
    rst_ni = 1'b1;
    // R1 nothing visible after only one edge
    @(posedge clk); @(negedge clk);
    check4("R1 one edge after release", 4'b1100);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule